// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block turns the raw, clock-asynchronous output of an analog comparator into a clean interrupt source. The raw bit runs through a multi-stage synchronizer. The synchronized level is shown to software as a status bit. An edge decoder then compares the synchronized level with its value one cycle earlier. It reports an event whenever that comparison matches the trigger class in a two-bit mode field.

A qualifying event sets a sticky pending flag. Software clears the flag by writing a one to the clear bit of the control word. The interrupt controller can also clear it by pulsing a vector-acknowledge input. The interrupt request is raised only while three conditions hold: the flag is set, the local enable is set and the global interrupt enable is high.

After reset, a small state machine in the synchronizer waits in `SYNC_FILL` until the flop chain holds real samples. Only then does it move to `SYNC_RUN`, so the level present at reset never shows up as a false edge. The pending flag is a two-state machine. `FLAG_CLEAR` moves to `FLAG_SET` on an event. `FLAG_SET` moves to `FLAG_CLEAR` on a clear that is not accompanied by an event. Every other combination keeps the current state.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset the readback shows mode 00, enable 0 and flag 0, and `irq` is 0.
- R2: A change on `cmp_raw` appears on the status bit (`rd_data[4]`) after exactly two rising clock edges. The synchronizer depth is `SYNC_STAGES`, default 2.
- R3: With mode 00 (`rd_data[1:0]`, written through `wr_data[1:0]`), a synchronized change in either direction sets the flag (`rd_data[3]`) on the third rising edge after the input changes.
- R4: Mode 10 sets the flag on falling edges only. Mode 11 sets it on rising edges only.
- R5: Mode 01 never sets the flag.
- R6: Once set, the flag stays set until a clear arrives.
- R7: A write (`wr_en` high) with `wr_data[3]`=1 clears the flag, and a pulse on `vec_ack` also clears it. A write with `wr_data[3]`=0 leaves the flag as it was. Every write loads the mode from `wr_data[1:0]` and the enable from `wr_data[2]`.
- R8: `irq` equals flag AND enable (`rd_data[2]`) AND `glb_ie`. With the enable at 0 the flag still records events.
- R9: When an event and a clear fall in the same cycle, the flag ends up set.
- R10: A comparator level held high through reset produces no event once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmp_raw | input | 1 | Raw comparator output, asynchronous |
| glb_ie | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Vector acknowledge, clears the flag |
| wr_en | input | 1 | Control-word write strobe |
| wr_data | input | 4 | Write data: [1:0] mode, [2] enable, [3] write one to clear the flag |
| rd_data | output | 5 | Readback: [1:0] mode, [2] enable, [3] flag, [4] status |
| irq | output | 1 | Interrupt request |

## Verification
The assertions take three things for granted. Reset is released synchronously. A clear (a write with the clear bit, or an acknowledge) lasts one cycle. The internal event line is the only thing that can set the flag.

The stimulus changes `cmp_raw` and every control input just after a falling edge. Each comparator level is held for at least three cycles, so every edge passes through the synchronizer intact. Same-cycle collisions are created deliberately, by timing a clear into the one cycle where the event is active.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_ANY  = 2'b00,
        TRIG_RSVD = 2'b01,
        TRIG_FALL = 2'b10,
        TRIG_RISE = 2'b11
    } trig_mode_e;

    typedef enum logic {
        SYNC_FILL = 1'b0,
        SYNC_RUN  = 1'b1
    } sync_state_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

    localparam int WR_W        = 4;
    localparam int RD_W        = 5;
    localparam int WR_ENA_BIT  = 2;
    localparam int WR_CLR_BIT  = 3;
    localparam int RD_ENA_BIT  = 2;
    localparam int RD_FLAG_BIT = 3;
    localparam int RD_STAT_BIT = 4;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync
    import cmp_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out,
    output logic prev_out,
    output logic armed
);
    localparam int CW = $clog2(STAGES + 1);

    logic [STAGES-1:0] chain;
    logic [CW-1:0]     fill_cnt;
    sync_state_e       state_q, state_d;

    // flop chain, one stage per generate iteration
    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

    // previous-value register, follows the synchronized level every cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_out <= 1'b0;
        else        prev_out <= sync_out;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= SYNC_FILL;
            fill_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SYNC_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // next state: leave FILL once the chain and the previous register hold real samples
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SYNC_FILL: if (fill_cnt == CW'(STAGES)) state_d = SYNC_RUN;
            SYNC_RUN:  state_d = SYNC_RUN;
        endcase
    end

    // outputs
    always_comb begin
        armed = 1'b0;
        unique case (state_q)
            SYNC_FILL: armed = 1'b0;
            SYNC_RUN:  armed = 1'b1;
        endcase
    end
endmodule

// File: rtl/cmp_edge_decode.sv
module cmp_edge_decode
    import cmp_irq_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       cur,
    input  logic       prev,
    input  logic       armed,
    output logic       evt
);
    logic rise, fall;

    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        evt = 1'b0;
        unique case (mode)
            TRIG_ANY:  evt = rise | fall;
            TRIG_RSVD: evt = 1'b0;
            TRIG_FALL: evt = fall;
            TRIG_RISE: evt = rise;
        endcase
        if (!armed) evt = 1'b0;
    end
endmodule

// File: rtl/cmp_flag_ctrl.sv
module cmp_flag_ctrl
    import cmp_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    input  logic            vec_ack,
    input  logic            glb_ie,
    input  logic            evt,
    output trig_mode_e      mode,
    output logic            ien,
    output logic            flag,
    output logic            irq
);
    flag_state_e state_q, state_d;
    logic        clr;

    // control fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= TRIG_ANY;
            ien  <= 1'b0;
        end else if (wr_en) begin
            mode <= trig_mode_e'(wr_data[1:0]);
            ien  <= wr_data[WR_ENA_BIT];
        end
    end

    assign clr = (wr_en & wr_data[WR_CLR_BIT]) | vec_ack;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    // next state: an event outranks a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (evt) state_d = FLAG_SET;
            FLAG_SET:   if (clr && !evt) state_d = FLAG_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        flag = 1'b0;
        unique case (state_q)
            FLAG_CLEAR: flag = 1'b0;
            FLAG_SET:   flag = 1'b1;
        endcase
        irq = flag & ien & glb_ie;
    end
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
    import cmp_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_raw,
    input  logic            glb_ie,
    input  logic            vec_ack,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic [RD_W-1:0] rd_data,
    output logic            irq
);
    logic       sync_lvl, prev_lvl, armed, evt_w, flag_w, ien_w;
    trig_mode_e mode_w;

    cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (cmp_raw),
        .sync_out (sync_lvl),
        .prev_out (prev_lvl),
        .armed    (armed)
    );

    cmp_edge_decode u_dec (
        .mode  (mode_w),
        .cur   (sync_lvl),
        .prev  (prev_lvl),
        .armed (armed),
        .evt   (evt_w)
    );

    cmp_flag_ctrl u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .vec_ack (vec_ack),
        .glb_ie  (glb_ie),
        .evt     (evt_w),
        .mode    (mode_w),
        .ien     (ien_w),
        .flag    (flag_w),
        .irq     (irq)
    );

    assign rd_data = {sync_lvl, flag_w, ien_w, mode_w};
endmodule

// File: rtl/cmp_irq_ctrl_chk.sv
module cmp_irq_ctrl_chk
    import cmp_irq_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            glb_ie,
    input logic            vec_ack,
    input logic            wr_en,
    input logic [WR_W-1:0] wr_data,
    input logic [RD_W-1:0] rd_data,
    input logic            irq,
    input logic            evt
);
    logic clr_any;
    assign clr_any = (wr_en & wr_data[WR_CLR_BIT]) | vec_ack;

    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (rd_data[RD_FLAG_BIT] & rd_data[RD_ENA_BIT] & glb_ie));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> rd_data[RD_FLAG_BIT]);

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_any && !evt) |=> !rd_data[RD_FLAG_BIT]);

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[RD_FLAG_BIT] && !clr_any) |=> rd_data[RD_FLAG_BIT]);

    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1:0] == 2'b01 && !rd_data[RD_FLAG_BIT]) |=> !rd_data[RD_FLAG_BIT]);

    a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && rd_data[1:0] == 2'b10) |-> !rd_data[RD_STAT_BIT]);

    a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && rd_data[1:0] == 2'b11) |-> rd_data[RD_STAT_BIT]);
endmodule

bind cmp_irq_ctrl cmp_irq_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .glb_ie  (glb_ie),
    .vec_ack (vec_ack),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq),
    .evt     (evt_w)
);

// File: tb/cmp_irq_ctrl_test.sv
module cmp_irq_ctrl_test;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b1;
    logic       glb_ie = 1'b1;
    logic       vec_ack = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [4:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    typedef struct {
        string      tag;
        logic [4:0] rd;
        logic       irq;
    } item_t;
    item_t sb[$];

    cmp_irq_ctrl uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmp_raw (cmp_raw),
        .glb_ie  (glb_ie),
        .vec_ack (vec_ack),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #(PERIOD/2) clk = ~clk;

    // driver side: queue an expectation for the current sample point
    task automatic expect_now(string tag, logic [4:0] rd, logic q);
        item_t it;
        it.tag = tag; it.rd = rd; it.irq = q;
        sb.push_back(it);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_ctl(logic [1:0] m, logic en, logic clr);
        @(negedge clk);
        wr_en = 1'b1; wr_data = {clr, en, m};
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        vec_ack = 1'b1;
        @(negedge clk);
        vec_ack = 1'b0;
    endtask

    task automatic set_raw(logic v);
        @(negedge clk);
        cmp_raw = v;
    endtask

    // monitor: compare outputs against queued expectations
    initial begin
        forever begin
            wait (sb.size() != 0);
            #1;
            begin
                item_t it;
                it = sb.pop_front();
                n_checks++;
                if (rd_data !== it.rd || irq !== it.irq) begin
                    n_errs++;
                    $display("FAIL %s: rd_data=%b irq=%b expected rd_data=%b irq=%b",
                             it.tag, rd_data, irq, it.rd, it.irq);
                end
            end
        end
    end

    initial begin
        #(200000 * PERIOD);
        if (!done) begin
            n_checks++; n_errs++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        // R1 R10: level high through reset, no event, registers cleared
        step(6);
        expect_now("R1_R10 reset state", 5'b10000, 1'b0);

        // R2 R3: falling in mode 00, enable off
        set_raw(1'b0);
        step(2);
        expect_now("R2 status after two edges", 5'b00000, 1'b0);
        step(1);
        expect_now("R3 toggle falling sets flag / R8 no irq", 5'b01000, 1'b0);

        // R7: clear by write one, enable on
        write_ctl(2'b00, 1'b1, 1'b1);
        expect_now("R7 write-one clears", 5'b00100, 1'b0);

        // R3: rising in mode 00
        set_raw(1'b1);
        step(3);
        expect_now("R3 toggle rising sets flag", 5'b11100, 1'b1);

        // R8: global enable gates irq
        @(negedge clk); glb_ie = 1'b0;
        expect_now("R8 global enable low", 5'b11100, 1'b0);
        @(negedge clk); glb_ie = 1'b1;

        // R7: writing zero to clear bit keeps flag
        write_ctl(2'b00, 1'b1, 1'b0);
        expect_now("R7 write-zero keeps flag", 5'b11100, 1'b1);

        // R7: vector acknowledge clears
        ack_pulse();
        expect_now("R7 acknowledge clears", 5'b10100, 1'b0);

        // R4: rising-only mode ignores a fall, catches a rise
        write_ctl(2'b11, 1'b1, 1'b0);
        set_raw(1'b0);
        step(3);
        expect_now("R4 rise mode ignores fall", 5'b00111, 1'b0);
        set_raw(1'b1);
        step(3);
        expect_now("R4 rise mode catches rise", 5'b11111, 1'b1);
        write_ctl(2'b10, 1'b1, 1'b1);
        expect_now("R7 clear while switching mode", 5'b10110, 1'b0);

        // R4: falling-only mode
        set_raw(1'b0);
        step(3);
        expect_now("R4 fall mode catches fall", 5'b01110, 1'b1);
        write_ctl(2'b10, 1'b1, 1'b1);
        set_raw(1'b1);
        step(3);
        expect_now("R4 fall mode ignores rise", 5'b10110, 1'b0);

        // R5: reserved mode
        write_ctl(2'b01, 1'b1, 1'b0);
        set_raw(1'b0);
        step(3);
        expect_now("R5 reserved ignores fall", 5'b00101, 1'b0);
        set_raw(1'b1);
        step(3);
        expect_now("R5 reserved ignores rise", 5'b10101, 1'b0);

        // R6: sticky flag
        write_ctl(2'b00, 1'b1, 1'b0);
        set_raw(1'b0);
        step(3);
        step(10);
        expect_now("R6 flag held", 5'b01100, 1'b1);

        // R9: event and clear collide
        write_ctl(2'b00, 1'b1, 1'b1);
        expect_now("R9 pre-clear", 5'b00100, 1'b0);
        set_raw(1'b1);
        step(2);
        vec_ack = 1'b1; wr_en = 1'b1; wr_data = 4'b1100;
        @(negedge clk);
        vec_ack = 1'b0; wr_en = 1'b0; wr_data = '0;
        expect_now("R9 set wins over clear", 5'b11100, 1'b1);
        ack_pulse();
        expect_now("R7 acknowledge after collision", 5'b10100, 1'b0);

        // R8: flag records while enable is off
        write_ctl(2'b00, 1'b0, 1'b0);
        set_raw(1'b0);
        step(3);
        expect_now("R8 flag records with enable off", 5'b01000, 1'b0);
        write_ctl(2'b00, 1'b1, 1'b0);
        expect_now("R8 enabling raises irq", 5'b01100, 1'b1);

        wait (sb.size() == 0);
        #2;
        done = 1;
        $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule